// File: doc/BRIEF.md
# Padded Vertex Count Encoder

This block takes the vertex count of a draw and works out the padded per-instance vertex count that instanced vertex processing steps through. The padded value is always an odd factor times a power of two. It is returned in two forms: a compact code of a 5-bit shift and a 3-bit odd index, and the expanded 32-bit count that the code stands for. Small counts follow a fixed lookup. Larger counts are rounded using only the four most significant bits of the count. This is not a round-up to the next power of two. In some cases the result can be smaller than the count.

A request is a one-cycle strobe carrying the vertex count and the instance count. Exactly two clock cycles later the block shows either a valid result or an error pulse. It accepts a new request every cycle. When the instance count is 0 or 1, the draw is not instanced: the code is forced to zero and the raw vertex count passes through. A zero vertex count is refused. So is an instanced count whose padding would need a shift wider than the 5-bit field.

Top module: `pad_vcount_enc`

## Requirements
- R1: A request strobed on `in_valid` gives exactly one cycle with `out_valid` or `out_err` high, two rising edges later. With no request, both stay low and every result field reads zero.
- R2: An instanced count from 1 to 19 pads through a fixed table. Counts 1..10 map to themselves. Counts 11 to 19 map to 12, 12, 14, 14, 16, 16, 18, 20, 20 in that order.
- R3: An instanced count of 20 or more uses a bit index n, equal to the index of the highest set bit minus 3, and a nibble made of bits n+3..n. When nibble bits 2:1 are 00, the result is 9<<n if nibble bit 0 is 1, and 5<<(n+1) if it is 0.
- R4: When nibble bits 2:1 are 01, the padded count is 3<<(n+2).
- R5: When nibble bits 2:1 are 10, the padded count is 7<<(n+1).
- R6: When nibble bits 2:1 are 11, the padded count is 1<<(n+4).
- R7: `out_shift` holds log2 of the power-of-two factor. `out_odd` holds (odd factor - 1)/2. `out_padded` equals (2*out_odd+1) << out_shift.
- R8: When the instance count is 0 or 1, a nonzero vertex count gives `out_valid` with shift 0, odd 0, and `out_padded` equal to the vertex count.
- R9: A zero vertex count raises `out_err` instead of `out_valid`, whatever the instance count, and all result fields read zero.
- R10: An instanced count with bit 31 set and nibble bits 2:1 equal to 11 would need a shift of 32. It raises `out_err` with zero fields. The same count with an instance count of 1 or less passes through as in R8.
- R11: Requests on consecutive cycles each produce their own result, in order, one per cycle. `out_valid` and `out_err` are never high together.
- R12: Synchronous reset clears both pipeline stages. All outputs read zero after it, including when a request was in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_vcount | input | 32 | Vertex count of the draw |
| in_icount | input | 32 | Instance count of the draw |
| out_valid | output | 1 | Result valid pulse |
| out_err | output | 1 | Request refused (zero count or shift overflow) |
| out_shift | output | 5 | Power-of-two exponent of the padded count |
| out_odd | output | 3 | Odd factor index, odd = 2*out_odd+1 |
| out_padded | output | 32 | Expanded padded count, or raw count when bypassed |

## Verification
A refusal and an accepted result can come out of the pipeline in neighbouring cycles. Meanwhile the first stage is already taking in the next request. The vector stream is built to provoke this. It issues a request every cycle and places zero counts and the overflowing count right next to valid instanced and bypassed requests. Each output cycle is judged against its own request's expected flags and fields. Error and valid must never be high together, and no field may carry over from the neighbouring request.

// File: rtl/pvc_pkg.sv
package pvc_pkg;

    localparam int CNT_W       = 32;
    localparam int SHIFT_W     = 5;
    localparam int ODD_W       = 3;
    localparam int POS_W       = $clog2(CNT_W);
    localparam int SMALL_LIMIT = 20;

    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        logic [ODD_W-1:0]   odd;
        logic               ovf;
    } pad_code_t;

    function automatic pad_code_t mk_code(input int sh, input int od);
        pad_code_t c;
        c.shift = sh[SHIFT_W-1:0];
        c.odd   = od[ODD_W-1:0];
        c.ovf   = 1'b0;
        return c;
    endfunction

    // Fixed padding for small counts: (shift, odd index)
    function automatic pad_code_t small_code(input logic [4:0] idx);
        case (idx)
            5'd1:          return mk_code(0, 0);
            5'd2:          return mk_code(1, 0);
            5'd3:          return mk_code(0, 1);
            5'd4:          return mk_code(2, 0);
            5'd5:          return mk_code(0, 2);
            5'd6:          return mk_code(1, 1);
            5'd7:          return mk_code(0, 3);
            5'd8:          return mk_code(3, 0);
            5'd9:          return mk_code(0, 4);
            5'd10:         return mk_code(1, 2);
            5'd11, 5'd12:  return mk_code(2, 1);
            5'd13, 5'd14:  return mk_code(1, 3);
            5'd15, 5'd16:  return mk_code(4, 0);
            5'd17:         return mk_code(1, 4);
            5'd18, 5'd19:  return mk_code(2, 2);
            default:       return mk_code(0, 0);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] expand(input logic [SHIFT_W-1:0] sh,
                                                 input logic [ODD_W-1:0]   od);
        logic [CNT_W-1:0] base;
        base = CNT_W'({od, 1'b1});
        return base << sh;
    endfunction

endpackage

// File: rtl/pvc_lead_one.sv
module pvc_lead_one #(
    parameter int W     = 32,
    localparam int PW   = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [PW-1:0] pos,
    output logic          any
);
    // Priority encoder: highest set bit wins
    always_comb begin
        pos = '0;
        any = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                pos = i[PW-1:0];
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pvc_classify.sv
module pvc_classify
    import pvc_pkg::*;
#(
    parameter int W     = CNT_W,
    localparam int PW   = $clog2(W)
) (
    input  logic [W-1:0]  count,
    input  logic [PW-1:0] msb,
    output pad_code_t     code
);
    logic [W-1:0] top_bits;
    logic [3:0]   nib;
    int           n;
    int           sh;
    int           od;

    always_comb begin
        n        = int'(msb) - 3;
        top_bits = count >> n;
        nib      = top_bits[3:0];
        sh       = 0;
        od       = 0;
        if (count < W'(SMALL_LIMIT)) begin
            code = small_code(count[4:0]);
        end else begin
            case (nib[2:1])
                2'b00: begin
                    if (nib[0]) begin sh = n;     od = 4; end
                    else        begin sh = n + 1; od = 2; end
                end
                2'b01:   begin sh = n + 2; od = 1; end
                2'b10:   begin sh = n + 1; od = 3; end
                default: begin sh = n + 4; od = 0; end
            endcase
            code       = mk_code(sh, od);
            code.ovf   = (sh > W - 1);
        end
    end
endmodule

// File: rtl/pad_vcount_enc.sv
module pad_vcount_enc
    import pvc_pkg::*;
#(
    parameter int CW    = CNT_W,
    localparam int PW   = $clog2(CW)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [CW-1:0]       in_vcount,
    input  logic [CW-1:0]       in_icount,
    output logic                out_valid,
    output logic                out_err,
    output logic [SHIFT_W-1:0]  out_shift,
    output logic [ODD_W-1:0]    out_odd,
    output logic [CW-1:0]       out_padded
);
    // Stage 1: leading-one search, registered with the request
    logic [PW-1:0] lead_pos;
    logic          lead_any;

    pvc_lead_one #(.W(CW)) u_lead (
        .vec (in_vcount),
        .pos (lead_pos),
        .any (lead_any)
    );

    logic          s1_valid;
    logic          s1_zero;
    logic          s1_inst;
    logic [PW-1:0] s1_msb;
    logic [CW-1:0] s1_count;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_zero  <= 1'b0;
            s1_inst  <= 1'b0;
            s1_msb   <= '0;
            s1_count <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_zero  <= !lead_any;
            s1_inst  <= (in_icount > CW'(1));
            s1_msb   <= lead_pos;
            s1_count <= in_vcount;
        end
    end

    // Stage 2: classify and pack the result
    pad_code_t code;

    pvc_classify #(.W(CW)) u_cls (
        .count (s1_count),
        .msb   (s1_msb),
        .code  (code)
    );

    logic reject;
    assign reject = s1_zero || (s1_inst && code.ovf);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_err    <= 1'b0;
            out_shift  <= '0;
            out_odd    <= '0;
            out_padded <= '0;
        end else begin
            out_valid  <= s1_valid && !reject;
            out_err    <= s1_valid && reject;
            out_shift  <= '0;
            out_odd    <= '0;
            out_padded <= '0;
            if (s1_valid && !reject) begin
                if (s1_inst) begin
                    out_shift  <= code.shift;
                    out_odd    <= code.odd;
                    out_padded <= expand(code.shift, code.odd);
                end else begin
                    out_padded <= s1_count;
                end
            end
        end
    end
endmodule

// File: rtl/pad_vcount_enc_chk.sv
module pad_vcount_enc_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_vcount,
    input logic [31:0] in_icount,
    input logic        out_valid,
    input logic        out_err,
    input logic [4:0]  out_shift,
    input logic [2:0]  out_odd,
    input logic [31:0] out_padded
);
    logic [1:0] seen;

    always_ff @(posedge clk) begin
        if (rst)             seen <= 2'd0;
        else if (seen != 2'd2) seen <= seen + 2'd1;
    end

    // R1: one response per request, two edges later
    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd2) |-> ((out_valid || out_err) == $past(in_valid, 2)));

    // R11: never valid and error together
    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_err));

    // R9: zero count is refused with cleared fields
    a_r9_zero_refused: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd2 && $past(in_valid, 2) && $past(in_vcount, 2) == 32'd0)
        |-> (out_err && out_shift == 5'd0 && out_odd == 3'd0 && out_padded == 32'd0));

    // R8: non-instanced draws pass the count through
    a_r8_bypass: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd2 && $past(in_valid, 2) && $past(in_icount, 2) <= 32'd1
         && $past(in_vcount, 2) != 32'd0)
        |-> (out_valid && out_shift == 5'd0 && out_odd == 3'd0
             && out_padded == $past(in_vcount, 2)));
endmodule

bind pad_vcount_enc pad_vcount_enc_chk u_chk (.*);

// File: tb/pad_vcount_enc_bench.sv
`timescale 1ns/1ps
module pad_vcount_enc_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_vcount = '0;
    logic [31:0] in_icount = '0;
    logic        out_valid;
    logic        out_err;
    logic [4:0]  out_shift;
    logic [2:0]  out_odd;
    logic [31:0] out_padded;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    pad_vcount_enc u_pad_vcount_enc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vcount(in_vcount),
        .in_icount(in_icount), .out_valid(out_valid), .out_err(out_err),
        .out_shift(out_shift), .out_odd(out_odd), .out_padded(out_padded)
    );

    localparam int NV = 18;
    // count, icount, shift, odd index, padded, error
    localparam logic [31:0] VC [NV] = '{32'd20, 32'd21, 32'd32, 32'd36, 32'd44, 32'd48,
        32'd60, 32'd1000, 32'd100000, 32'h8000_0000, 32'h9FFF_FFFF, 32'hE000_0000,
        32'h7FFF_FFFF, 32'd1000, 32'd7, 32'd0, 32'd0, 32'hE000_0000};
    localparam logic [31:0] VI [NV] = '{32'd4, 32'd4, 32'd4, 32'd4, 32'd4, 32'd4,
        32'd4, 32'd4, 32'd4, 32'd4, 32'd4, 32'd4, 32'd4, 32'd1, 32'd0, 32'd4, 32'd1, 32'd1};
    localparam logic [4:0] ES [NV] = '{5'd3, 5'd3, 5'd3, 5'd2, 5'd4, 5'd3,
        5'd6, 5'd10, 5'd14, 5'd29, 5'd28, 5'd0, 5'd31, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0};
    localparam logic [2:0] EO [NV] = '{3'd1, 3'd1, 3'd2, 3'd4, 3'd1, 3'd3,
        3'd0, 3'd0, 3'd3, 3'd2, 3'd4, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0};
    localparam logic [31:0] EP [NV] = '{32'd24, 32'd24, 32'd40, 32'd36, 32'd48, 32'd56,
        32'd64, 32'd1024, 32'd114688, 32'hA000_0000, 32'h9000_0000, 32'd0,
        32'h8000_0000, 32'd1000, 32'd7, 32'd0, 32'd0, 32'hE000_0000};
    localparam logic EE [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    string TAG [NV] = '{"R4", "R4", "R3", "R3", "R4", "R5", "R6", "R6", "R5",
        "R3", "R3", "R10", "R6", "R8", "R8", "R9", "R9", "R10"};

    // R2 padded values for counts 1..19
    localparam int SMALL_PAD [19] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10,
        12, 12, 14, 14, 16, 16, 18, 20, 20};

    task automatic chk(input string tag, input logic ev, input logic ee,
                       input logic [4:0] es, input logic [2:0] eo, input logic [31:0] ep);
        checks++;
        if (out_valid !== ev || out_err !== ee || out_shift !== es ||
            out_odd !== eo || out_padded !== ep) begin
            errors++;
            $display("FAIL %s: got v=%0b e=%0b sh=%0d od=%0d pad=%08h, expected v=%0b e=%0b sh=%0d od=%0d pad=%08h",
                     tag, out_valid, out_err, out_shift, out_odd, out_padded,
                     ev, ee, es, eo, ep);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] c, input logic [31:0] ic);
        in_valid  = v;
        in_vcount = c;
        in_icount = ic;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12", 1'b0, 1'b0, 5'd0, 3'd0, 32'd0);

        // Vector table streamed back to back (R11)
        for (int k = 0; k < NV + 2; k++) begin
            @(negedge clk);
            if (k >= 2)
                chk(TAG[k-2], !EE[k-2], EE[k-2], ES[k-2], EO[k-2], EP[k-2]);
            if (k < NV) drive(1'b1, VC[k], VI[k]);
            else        drive(1'b0, 32'd0, 32'd0);
        end

        // R2 small table, R7 code derived from the padded value
        for (int k = 0; k < 21; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                int p;
                int s;
                p = SMALL_PAD[k-2];
                s = 0;
                while (((p >> s) & 1) == 0) s++;
                chk("R2", 1'b1, 1'b0, s[4:0], 3'(((p >> s) - 1) / 2), 32'(p));
            end
            if (k < 19) drive(1'b1, 32'(k + 1), 32'd2);
            else        drive(1'b0, 32'd0, 32'd0);
        end

        // R1 single pulse timing, R7 expansion
        @(negedge clk);
        drive(1'b1, 32'd36, 32'd3);
        @(negedge clk);
        drive(1'b0, 32'd0, 32'd0);
        chk("R1", 1'b0, 1'b0, 5'd0, 3'd0, 32'd0);
        @(negedge clk);
        chk("R7", 1'b1, 1'b0, 5'd2, 3'd4, 32'd36);
        @(negedge clk);
        chk("R1", 1'b0, 1'b0, 5'd0, 3'd0, 32'd0);

        // R12 reset while a request is in flight
        drive(1'b1, 32'd20, 32'd4);
        @(negedge clk);
        drive(1'b0, 32'd0, 32'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R12", 1'b0, 1'b0, 5'd0, 3'd0, 32'd0);
        @(negedge clk);
        chk("R12", 1'b0, 1'b0, 5'd0, 3'd0, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule